// File: doc/BRIEF.md
# Multiple Stuck-At Fault Emulator

This block is a combinational wrapper placed on a group of N internal signal lines of a circuit under test. It reproduces a stuck-at fault of multiplicity N, where each line carries its own stuck polarity, as one single stuck-at fault on a shared activation node. Tools that inject only single faults can therefore exercise multiple-fault scenarios.

Each line passes through its own two-input in-line gate. A line stuck at 1 gets an OR gate. A line stuck at 0 gets an AND gate. The other input of every in-line gate comes from one shared N-input AND gate, the activation gate. Each stuck-at-1 line feeds the activation gate directly, and each stuck-at-0 line feeds it through an inverter. The activation output goes straight to the OR gates and through one inverter to the AND gates.

While the activation node is left free, the wrapper is logically transparent. Asserting the force input emulates a stuck-at-1 on the activation node, and every line then takes its stuck value at once. A bypass input returns the raw lines whatever the mask and force values are.

Top module: `stuck_fault_emulator`

## Requirements
- R1: With bypass low and force high, every output bit whose mask bit is 0 (stuck-at-0) reads 0.
- R2: With bypass low and force high, every output bit whose mask bit is 1 (stuck-at-1) reads 1.
- R3: With bypass low and force low, line_out equals line_in for every combination of line values and mask.
- R4: With bypass high, line_out equals line_in whatever the values of force and mask.
- R5: With bypass low and force high, the whole of line_out equals the mask in the same evaluation, so all lines take their stuck values together.
- R6: With bypass low and force low, the case where every line already sits at its stuck value (line_in equals the mask, so the activation gate fires on its own) still leaves line_out equal to line_in.
- R7: The block works at the minimum width N = 1 with the same rules.
- R8: The block is purely combinational. It holds no clock and no state, so any output depends only on the inputs present in that evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_in | input | N | Fault-free values of the wrapped lines |
| sa1_mask | input | N | Per-line polarity: 1 means stuck-at-1, 0 means stuck-at-0 |
| act_force | input | 1 | Emulated stuck-at-1 on the shared activation node |
| bypass | input | 1 | When high, the outputs mirror line_in |
| line_out | output | N | Modified line values |

## Verification
Two functions can coincide in the same evaluation. The first is the activation gate firing on its own, when line_in already equals the mask. The second is the external force or the bypass. The sweep visits every pairing of line values, mask, force and bypass for N = 4, so each of these overlaps occurs. The expected result is computed arithmetically in the bench, with bypass taking priority over force and force giving the mask. Activation that fires on its own while force is low must leave the lines untouched. A second instance with N = 1 repeats the sweep at the minimum width.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic {
        POL_SA0 = 1'b0,
        POL_SA1 = 1'b1
    } stuck_pol_e;

    typedef struct packed {
        logic       good;
        stuck_pol_e pol;
    } line_ctl_t;

    // Term a line contributes to the activation gate: direct for SA1, inverted for SA0.
    function automatic logic act_term(input line_ctl_t c);
        return (c.pol == POL_SA1) ? c.good : ~c.good;
    endfunction

    // In-line gate: OR with activation for SA1, AND with inverted activation for SA0.
    function automatic logic inline_eval(input line_ctl_t c, input logic act_hi, input logic act_lo_n);
        return (c.pol == POL_SA1) ? (c.good | act_hi) : (c.good & act_lo_n);
    endfunction

endpackage

// File: rtl/sfe_act_gate.sv
module sfe_act_gate
    import sfe_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] line_in,
    input  logic [N-1:0] sa1_mask,
    input  logic         act_force,
    output logic         act_node,
    output logic         act_node_n
);

    logic [N-1:0] terms;
    logic         act_raw;

    for (genvar g = 0; g < N; g++) begin : g_term
        line_ctl_t ctl;
        always_comb begin
            ctl.good = line_in[g];
            ctl.pol  = stuck_pol_e'(sa1_mask[g]);
            terms[g] = act_term(ctl);
        end
    end

    assign act_raw    = &terms;
    // The forced stuck-at-1 sits on the activation gate output.
    assign act_node   = act_raw | act_force;
    assign act_node_n = ~act_node;

endmodule

// File: rtl/sfe_inline_gate.sv
module sfe_inline_gate
    import sfe_pkg::*;
(
    input  logic good,
    input  logic sa1_pol,
    input  logic act_node,
    input  logic act_node_n,
    output logic faulty
);

    line_ctl_t ctl;

    always_comb begin
        ctl.good = good;
        ctl.pol  = stuck_pol_e'(sa1_pol);
        faulty   = inline_eval(ctl, act_node, act_node_n);
    end

endmodule

// File: rtl/sfe_bypass_mux.sv
module sfe_bypass_mux #(
    parameter int N = 4
) (
    input  logic         bypass,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] modified,
    output logic [N-1:0] sel
);

    assign sel = bypass ? raw : modified;

endmodule

// File: rtl/stuck_fault_emulator.sv
module stuck_fault_emulator #(
    parameter int N = 4
) (
    input  logic [N-1:0] line_in,
    input  logic [N-1:0] sa1_mask,
    input  logic         act_force,
    input  logic         bypass,
    output logic [N-1:0] line_out
);

    logic         act_node;
    logic         act_node_n;
    logic [N-1:0] modified;

    sfe_act_gate #(.N(N)) act_i (
        .line_in    (line_in),
        .sa1_mask   (sa1_mask),
        .act_force  (act_force),
        .act_node   (act_node),
        .act_node_n (act_node_n)
    );

    for (genvar g = 0; g < N; g++) begin : g_line
        sfe_inline_gate gate_i (
            .good       (line_in[g]),
            .sa1_pol    (sa1_mask[g]),
            .act_node   (act_node),
            .act_node_n (act_node_n),
            .faulty     (modified[g])
        );
    end

    sfe_bypass_mux #(.N(N)) mux_i (
        .bypass   (bypass),
        .raw      (line_in),
        .modified (modified),
        .sel      (line_out)
    );

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int N = 4
) (
    input logic [N-1:0] line_in,
    input logic [N-1:0] sa1_mask,
    input logic         act_force,
    input logic         bypass,
    input logic [N-1:0] line_out
);

    always_comb begin
        if (!$isunknown({line_in, sa1_mask, act_force, bypass, line_out})) begin
            if (bypass) begin
                a_r4_bypass_mirror: assert (line_out == line_in)
                    else $error("R4 bypass output differs from input");
            end else if (act_force) begin
                a_r1_sa0_low: assert ((line_out & ~sa1_mask) == '0)
                    else $error("R1 stuck-at-0 line not low");
                a_r2_sa1_high: assert ((line_out & sa1_mask) == sa1_mask)
                    else $error("R2 stuck-at-1 line not high");
            end else begin
                a_r3_transparent: assert (line_out == line_in)
                    else $error("R3 unforced output differs from input");
            end
        end
    end

endmodule

bind stuck_fault_emulator sfe_checker #(.N(N)) chk_i (
    .line_in   (line_in),
    .sa1_mask  (sa1_mask),
    .act_force (act_force),
    .bypass    (bypass),
    .line_out  (line_out)
);

// File: tb/stuck_fault_emulator_tb_top.sv
`timescale 1ns/1ps
module stuck_fault_emulator_tb_top;

    localparam int W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [W-1:0] line_in, sa1_mask, line_out;
    logic         act_force, bypass;
    logic         s_in, s_mask, s_out, s_force, s_byp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    stuck_fault_emulator #(.N(W)) dut_i (
        .line_in(line_in), .sa1_mask(sa1_mask), .act_force(act_force),
        .bypass(bypass), .line_out(line_out)
    );

    stuck_fault_emulator #(.N(1)) dut_n1_i (
        .line_in(s_in), .sa1_mask(s_mask), .act_force(s_force),
        .bypass(s_byp), .line_out(s_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b (in=%b mask=%b force=%b byp=%b)",
                     req, act, exp, line_in, sa1_mask, act_force, bypass);
        end
    endtask

    initial begin
        line_in = '0; sa1_mask = '0; act_force = 1'b0; bypass = 1'b0;
        s_in = 1'b0; s_mask = 1'b0; s_force = 1'b0; s_byp = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R3 idle", line_out, '0);

        for (int b = 0; b < 2; b++)
            for (int f = 0; f < 2; f++)
                for (int m = 0; m < (1 << W); m++)
                    for (int v = 0; v < (1 << W); v++) begin
                        @(posedge clk);
                        line_in = W'(v); sa1_mask = W'(m);
                        act_force = f[0]; bypass = b[0];
                        @(negedge clk);
                        if (b != 0)
                            check("R4", line_out, W'(v));
                        else if (f != 0) begin
                            check("R1", line_out & ~W'(m), '0);
                            check("R2", line_out & W'(m), W'(m));
                            check("R5", line_out, W'(m));
                        end else if (v == m)
                            check("R6", line_out, W'(v));
                        else
                            check("R3", line_out, W'(v));
                    end

        // R8: the same input pattern gives the same output, whatever came before.
        @(posedge clk);
        line_in = 4'b1010; sa1_mask = 4'b0110; act_force = 1'b1; bypass = 1'b0;
        @(negedge clk);
        check("R8 forced", line_out, 4'b0110);
        @(posedge clk);
        act_force = 1'b0;
        @(negedge clk);
        check("R8 released", line_out, 4'b1010);

        // R7: minimum width
        for (int b = 0; b < 2; b++)
            for (int f = 0; f < 2; f++)
                for (int m = 0; m < 2; m++)
                    for (int v = 0; v < 2; v++) begin
                        @(posedge clk);
                        s_in = v[0]; s_mask = m[0]; s_force = f[0]; s_byp = b[0];
                        @(negedge clk);
                        check("R7", {3'b0, s_out},
                              {3'b0, (b != 0) ? v[0] : ((f != 0) ? m[0] : v[0])});
                    end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule